// File: doc/BRIEF.md
# USB Device Interrupt Status Controller

This block holds the interrupt status word of a USB high-speed device controller. The protocol engine sends it single-cycle event pulses: a full start-of-frame token with the frame number it carries, a micro start-of-frame token, end of bus reset, remote wakeup, end of resume and upstream resume. It also receives a bus-idle (J state) level, a high-speed indication, and level requests from eight endpoints and six DMA channels. The block latches the event pulses as sticky flags and merges them with the live levels into one 32-bit status word.

Software clears a sticky flag by writing a 1 at that flag's position through a separate clear strobe. An enable register, loaded through its own write strobe, masks the status word, and any unmasked set bit raises the single interrupt line. The block also maintains the frame and microframe counters, which are visible as separate outputs. It contains the suspend detector, a small state machine with an idle-cycle counter. Its states are IDLE_WAIT (bus active), IDLE_COUNT (counting consecutive idle cycles) and SUSPENDED (detection done). It has four transitions. START goes from IDLE_WAIT to IDLE_COUNT on an idle cycle. ABORT goes from IDLE_COUNT back to IDLE_WAIT on any activity. HIT goes from IDLE_COUNT to SUSPENDED when the idle run reaches the limit, and it raises the suspend flag. WAKE goes from SUSPENDED to IDLE_WAIT on activity.

Top module: `usb_dev_irq_status`

## Requirements
- R1: The status word places the live high-speed indication at bit 0, endpoint levels 0..7 at bits 8..15, and DMA channel levels 1..6 (dma_level[0..5]) at bits 25..30. Bits 16..24 and 31 always read 0.
- R2: A one-cycle pulse on ev_reset_end, ev_wake, ev_resume_end or ev_up_resume sets the sticky flag at bit 4, 5, 6 or 7 respectively. The flag is visible after the clock edge that samples the pulse and stays set until cleared.
- R3: A cycle with clr_we high clears every sticky flag (bits 1..7) whose position in clr_data is 1. Flags whose position holds 0 are not affected, and neither are the live bits (0, 8..15, 25..30).
- R4: If a flag's hardware set and its software clear occur in the same cycle, the flag ends set.
- R5: irq is high exactly when some status bit and the same bit of the enable register are both 1. The enable register is loaded from en_data in a cycle with en_we high, and it resets to 0.
- R6: A micro start-of-frame pulse sets bit 2, increments the 3-bit microframe number modulo 8, and leaves the frame number unchanged.
- R7: A start-of-frame pulse sets bit 3, loads the 11-bit frame number from sof_frame, and clears the microframe number to 0.
- R8: If both frame pulses arrive in the same cycle, the block acts on the start-of-frame only: bit 2 is not set and the microframe number goes to 0.
- R9: Bit 1 is set on the edge that samples the IDLE_CYCLES-th consecutive cycle of bus_idle high. Any cycle with bus_idle low restarts the count.
- R10: Only one suspend detection occurs per idle period. If the flag is cleared while the bus stays idle, it is not set again until the bus has gone active and then idle for a further full period.
- R11: After reset, all sticky flags, the enable register, the frame number and the microframe number are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_mode | input | 1 | 1 while the link runs at high speed |
| bus_idle | input | 1 | 1 while the bus sits idle in the J state |
| ev_sof | input | 1 | Start-of-frame token pulse |
| ev_usof | input | 1 | Micro start-of-frame token pulse |
| sof_frame | input | 11 | Frame number carried by the start-of-frame token |
| ev_reset_end | input | 1 | End of bus reset pulse |
| ev_wake | input | 1 | Wakeup pulse |
| ev_resume_end | input | 1 | End of resume pulse |
| ev_up_resume | input | 1 | Upstream resume pulse |
| ep_level | input | 8 | Endpoint interrupt levels |
| dma_level | input | 6 | DMA channel interrupt levels |
| clr_we | input | 1 | Clear strobe |
| clr_data | input | 32 | Write-1-to-clear data |
| en_we | input | 1 | Enable register write strobe |
| en_data | input | 32 | Enable register write data |
| status | output | 32 | Status word |
| irq | output | 1 | Interrupt line |
| frame_num | output | 11 | Current frame number |
| uframe_num | output | 3 | Current microframe number |

## Verification
Sticky flags, the frame and microframe numbers and the enable register all change on the clock edge that samples their pulse or strobe. The bench therefore drives on a falling edge and checks on the next falling edge, one register stage later. The live bits and irq are combinational from inputs and registers, so they are checked on the same falling edge that follows the stimulus. The suspend flag is due on the edge that samples the IDLE_CYCLES-th idle cycle. The bench counts falling edges from the moment it raises bus_idle, checks a zero one edge before the flag is due, and checks a one on the due edge.

// File: rtl/usbis_pkg.sv
package usbis_pkg;
    localparam int STAT_W      = 32;
    localparam int NUM_EV      = 7;   // sticky flags occupy bits 1..7
    localparam int BIT_SPEED   = 0;
    localparam int BIT_SUSP    = 1;
    localparam int BIT_USOF    = 2;
    localparam int BIT_SOF     = 3;
    localparam int BIT_RSTEND  = 4;
    localparam int BIT_WAKE    = 5;
    localparam int BIT_RSMEND  = 6;
    localparam int BIT_UPRES   = 7;
    localparam int EP_LSB      = 8;
    localparam int NUM_EP      = 8;
    localparam int DMA_LSB     = 25;
    localparam int NUM_DMA     = 6;

    typedef enum logic [1:0] {
        IDLE_WAIT  = 2'd0,
        IDLE_COUNT = 2'd1,
        SUSPENDED  = 2'd2
    } susp_state_t;
endpackage

// File: rtl/usbis_suspend_fsm.sv
module usbis_suspend_fsm
    import usbis_pkg::*;
#(
    parameter int IDLE_CYCLES = 180000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_idle,
    output logic susp_hit
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYCLES - 1);

    susp_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IDLE_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            IDLE_WAIT: begin
                if (bus_idle) begin          // START
                    state_d = IDLE_COUNT;
                    cnt_d   = CNT_W'(1);
                end
            end
            IDLE_COUNT: begin
                if (!bus_idle) begin         // ABORT
                    state_d = IDLE_WAIT;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin  // HIT
                    state_d = SUSPENDED;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q + CNT_W'(1);
                end
            end
            SUSPENDED: begin
                if (!bus_idle) begin         // WAKE
                    state_d = IDLE_WAIT;
                end
            end
            default: begin
                state_d = IDLE_WAIT;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        susp_hit = (state_q == IDLE_COUNT) && bus_idle && (cnt_q == LAST);
    end
endmodule

// File: rtl/usbis_frame_ctr.sv
module usbis_frame_ctr #(
    parameter int FRAME_W  = 11,
    parameter int UFRAME_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sof,
    input  logic                usof,
    input  logic [FRAME_W-1:0]  sof_frame,
    output logic [FRAME_W-1:0]  frame_num,
    output logic [UFRAME_W-1:0] uframe_num
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_num  <= '0;
            uframe_num <= '0;
        end else if (sof) begin
            frame_num  <= sof_frame;
            uframe_num <= '0;
        end else if (usof) begin
            uframe_num <= uframe_num + UFRAME_W'(1);
        end
    end
endmodule

// File: rtl/usbis_flag_bank.sv
module usbis_flag_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[g] <= 1'b0;
            else if (set[g])
                flags[g] <= 1'b1;
            else if (clr[g])
                flags[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/usb_dev_irq_status.sv
module usb_dev_irq_status
    import usbis_pkg::*;
#(
    parameter int IDLE_CYCLES = 180000,
    parameter int FRAME_W     = 11,
    parameter int UFRAME_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hs_mode,
    input  logic                 bus_idle,
    input  logic                 ev_sof,
    input  logic                 ev_usof,
    input  logic [FRAME_W-1:0]   sof_frame,
    input  logic                 ev_reset_end,
    input  logic                 ev_wake,
    input  logic                 ev_resume_end,
    input  logic                 ev_up_resume,
    input  logic [NUM_EP-1:0]    ep_level,
    input  logic [NUM_DMA-1:0]   dma_level,
    input  logic                 clr_we,
    input  logic [STAT_W-1:0]    clr_data,
    input  logic                 en_we,
    input  logic [STAT_W-1:0]    en_data,
    output logic [STAT_W-1:0]    status,
    output logic                 irq,
    output logic [FRAME_W-1:0]   frame_num,
    output logic [UFRAME_W-1:0]  uframe_num
);
    logic               susp_hit;
    logic               usof_only;
    logic [NUM_EV-1:0]  ev_set, ev_clr, ev_flags;
    logic [STAT_W-1:0]  en_q;
    logic               unused_clr;

    assign usof_only = ev_usof & ~ev_sof;

    usbis_suspend_fsm #(.IDLE_CYCLES(IDLE_CYCLES)) u_susp (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_idle (bus_idle),
        .susp_hit (susp_hit)
    );

    usbis_frame_ctr #(.FRAME_W(FRAME_W), .UFRAME_W(UFRAME_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof        (ev_sof),
        .usof       (ev_usof),
        .sof_frame  (sof_frame),
        .frame_num  (frame_num),
        .uframe_num (uframe_num)
    );

    // ev vector index i maps to status bit i+1
    assign ev_set = {ev_up_resume, ev_resume_end, ev_wake, ev_reset_end,
                     ev_sof, usof_only, susp_hit};
    assign ev_clr = clr_we ? clr_data[NUM_EV:1] : '0;
    assign unused_clr = ^{clr_data[STAT_W-1:NUM_EV+1], clr_data[0]};

    usbis_flag_bank #(.N(NUM_EV)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ev_set),
        .clr   (ev_clr),
        .flags (ev_flags)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_we)
            en_q <= en_data;
    end

    always_comb begin
        status = '0;
        status[BIT_SPEED]                 = hs_mode;
        status[NUM_EV:1]                  = ev_flags;
        status[EP_LSB +: NUM_EP]          = ep_level;
        status[DMA_LSB +: NUM_DMA]        = dma_level;
        irq = |(status & en_q);
    end
endmodule

// File: rtl/usbis_chk.sv
module usbis_chk #(
    parameter int IDLE_CYCLES = 180000,
    parameter int FRAME_W     = 11,
    parameter int UFRAME_W    = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_idle,
    input logic                ev_sof,
    input logic                ev_usof,
    input logic [FRAME_W-1:0]  sof_frame,
    input logic                ev_wake,
    input logic                ev_resume_end,
    input logic                clr_we,
    input logic [31:0]         clr_data,
    input logic [31:0]         status,
    input logic                irq,
    input logic [FRAME_W-1:0]  frame_num,
    input logic [UFRAME_W-1:0] uframe_num
);
    localparam int RUN_W = $clog2(IDLE_CYCLES + 2);
    logic [RUN_W-1:0] idle_run;

    always_ff @(posedge clk) begin
        if (!rst_n)
            idle_run <= '0;
        else if (!bus_idle)
            idle_run <= '0;
        else if (idle_run != RUN_W'(IDLE_CYCLES + 1))
            idle_run <= idle_run + RUN_W'(1);
    end

    // R2
    wake_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wake |=> status[5]);
    // R3
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_data[6] && !ev_resume_end) |=> !status[6]);
    // R4
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wake && clr_we && clr_data[5]) |=> status[5]);
    // R5
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));
    // R6
    usof_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_usof && !ev_sof) |=> (uframe_num == $past(uframe_num) + UFRAME_W'(1))
                                 && (frame_num == $past(frame_num)));
    // R7
    sof_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sof |=> (uframe_num == '0) && (frame_num == $past(sof_frame)));
    // R8
    no_dual_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sof && ev_usof && !status[2]) |=> !status[2]);
    // R9
    susp_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> (idle_run >= RUN_W'(IDLE_CYCLES)));
endmodule

bind usb_dev_irq_status usbis_chk #(
    .IDLE_CYCLES(IDLE_CYCLES), .FRAME_W(FRAME_W), .UFRAME_W(UFRAME_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .ev_sof(ev_sof),
    .ev_usof(ev_usof), .sof_frame(sof_frame), .ev_wake(ev_wake),
    .ev_resume_end(ev_resume_end), .clr_we(clr_we), .clr_data(clr_data),
    .status(status), .irq(irq), .frame_num(frame_num), .uframe_num(uframe_num)
);

// File: tb/sim_usb_dev_irq_status.sv
module sim_usb_dev_irq_status;
    localparam int IDLE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs_mode = 1'b0, bus_idle = 1'b0;
    logic        ev_sof = 1'b0, ev_usof = 1'b0;
    logic [10:0] sof_frame = '0;
    logic        ev_reset_end = 1'b0, ev_wake = 1'b0;
    logic        ev_resume_end = 1'b0, ev_up_resume = 1'b0;
    logic [7:0]  ep_level = '0;
    logic [5:0]  dma_level = '0;
    logic        clr_we = 1'b0, en_we = 1'b0;
    logic [31:0] clr_data = '0, en_data = '0;
    logic [31:0] status;
    logic        irq;
    logic [10:0] frame_num;
    logic [2:0]  uframe_num;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    usb_dev_irq_status #(.IDLE_CYCLES(IDLE)) u0 (
        .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .bus_idle(bus_idle),
        .ev_sof(ev_sof), .ev_usof(ev_usof), .sof_frame(sof_frame),
        .ev_reset_end(ev_reset_end), .ev_wake(ev_wake),
        .ev_resume_end(ev_resume_end), .ev_up_resume(ev_up_resume),
        .ep_level(ep_level), .dma_level(dma_level),
        .clr_we(clr_we), .clr_data(clr_data), .en_we(en_we), .en_data(en_data),
        .status(status), .irq(irq), .frame_num(frame_num), .uframe_num(uframe_num)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic drive_ev(input int k, input logic v);
        case (k)
            2: ev_usof = v;
            3: ev_sof = v;
            4: ev_reset_end = v;
            5: ev_wake = v;
            6: ev_resume_end = v;
            default: ev_up_resume = v;
        endcase
    endtask

    task automatic write_en(input logic [31:0] v);
        en_we = 1'b1; en_data = v; step(); en_we = 1'b0;
    endtask

    task automatic write_clr(input logic [31:0] v);
        clr_we = 1'b1; clr_data = v; step(); clr_we = 1'b0; clr_data = '0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R11 reset state
        chk("R11 status", status, 32'h0);
        chk("R11 irq", {31'b0, irq}, 32'h0);
        chk("R11 frame", {21'b0, frame_num}, 32'h0);
        chk("R11 uframe", {29'b0, uframe_num}, 32'h0);
        write_en(32'hFFFF_FFFF);
        chk("R11 en reset then load irq", {31'b0, irq}, 32'h0);
        write_en(32'h0);

        // R1 live bit placement
        for (int i = 0; i < 8; i++) begin
            ep_level = 8'(1 << i); step();
            chk("R1 ep bit", status, 32'(1) << (8 + i));
        end
        ep_level = '0;
        for (int j = 0; j < 6; j++) begin
            dma_level = 6'(1 << j); step();
            chk("R1 dma bit", status, 32'(1) << (25 + j));
        end
        dma_level = '0;
        hs_mode = 1'b1; step();
        chk("R1 speed hs", status, 32'h1);
        hs_mode = 1'b0; step();
        chk("R1 speed fs", status, 32'h0);

        // R2/R6/R7 set, R5 masking, R3 clearing
        for (int k = 2; k < 8; k++) begin
            drive_ev(k, 1'b1); step(); drive_ev(k, 1'b0);
            chk("R2 flag set", status, 32'(1) << k);
            chk("R5 irq masked", {31'b0, irq}, 32'h0);
            step();
            chk("R2 flag sticky", status, 32'(1) << k);
            write_en(~(32'(1) << k));
            chk("R5 irq other bits", {31'b0, irq}, 32'h0);
            write_en(32'(1) << k);
            chk("R5 irq enabled", {31'b0, irq}, 32'h1);
            ep_level = 8'hFF; dma_level = 6'h3F; hs_mode = 1'b1;
            write_clr(~(32'(1) << k));
            chk("R3 other clear no effect", status,
                (32'(1) << k) | 32'h7E00_FF01);
            ep_level = '0; dma_level = '0; hs_mode = 1'b0;
            write_clr(32'(1) << k);
            chk("R3 flag cleared", status, 32'h0);
            chk("R5 irq dropped", {31'b0, irq}, 32'h0);
            write_en(32'h0);
        end

        // R4 set wins
        for (int k = 2; k < 8; k++) begin
            drive_ev(k, 1'b1); clr_we = 1'b1; clr_data = 32'hFFFF_FFFF;
            step();
            drive_ev(k, 1'b0); clr_we = 1'b0; clr_data = '0;
            chk("R4 set wins", status, 32'(1) << k);
            write_clr(32'hFFFF_FFFF);
        end

        // R7 / R6 counters
        sof_frame = 11'h5A3; ev_sof = 1'b1; step(); ev_sof = 1'b0;
        chk("R7 frame load", {21'b0, frame_num}, 32'h5A3);
        chk("R7 uframe zero", {29'b0, uframe_num}, 32'h0);
        for (int n = 1; n <= 10; n++) begin
            ev_usof = 1'b1; step(); ev_usof = 1'b0;
            chk("R6 uframe step", {29'b0, uframe_num}, 32'(n % 8));
            chk("R6 frame hold", {21'b0, frame_num}, 32'h5A3);
        end
        sof_frame = 11'h7FF; ev_sof = 1'b1; step(); ev_sof = 1'b0;
        chk("R7 frame max", {21'b0, frame_num}, 32'h7FF);
        chk("R7 uframe clr", {29'b0, uframe_num}, 32'h0);
        ev_usof = 1'b1; step(); step(); ev_usof = 1'b0;
        write_clr(32'hFFFF_FFFF);
        sof_frame = 11'h123; ev_sof = 1'b1; ev_usof = 1'b1; step();
        ev_sof = 1'b0; ev_usof = 1'b0;
        chk("R8 only sof flag", status, 32'h8);
        chk("R8 uframe zero", {29'b0, uframe_num}, 32'h0);
        chk("R8 frame", {21'b0, frame_num}, 32'h123);
        write_clr(32'hFFFF_FFFF);

        // R5 with live endpoint level
        write_en(32'h100);
        ep_level = 8'h01; step();
        chk("R5 ep irq", {31'b0, irq}, 32'h1);
        ep_level = 8'h02; step();
        chk("R5 ep masked", {31'b0, irq}, 32'h0);
        ep_level = '0; write_en(32'h0);

        // R9 suspend timing
        bus_idle = 1'b1;
        repeat (IDLE - 1) step();
        chk("R9 not yet", status, 32'h0);
        bus_idle = 1'b0; step();
        bus_idle = 1'b1;
        repeat (IDLE - 1) step();
        chk("R9 restarted", status, 32'h0);
        step();
        chk("R9 detected", status, 32'h2);
        // R10 single detection
        write_clr(32'h2);
        repeat (3 * IDLE) step();
        chk("R10 no repeat", status, 32'h0);
        bus_idle = 1'b0; repeat (2) step();
        bus_idle = 1'b1;
        repeat (IDLE) step();
        chk("R10 new period", status, 32'h2);
        bus_idle = 1'b0;
        write_clr(32'h2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule